// File: doc/BRIEF.md
# Ratio-selectable sample demultiplexer with aligned data-ready clock

The block takes one 10-bit sample per sample-clock period and spreads consecutive samples over four output words, A to D, using either a 1:4 ratio (all four ports) or a 1:2 ratio (ports A and B only). In simultaneous release, the active ports load together once a group of samples is complete. In staggered release, each port loads its own sample as soon as that sample has run through the pipeline. A data-ready clock follows port A. Its edges are placed at the middle of each output word. It either runs at twice the word rate (full-rate mode) or toggles once per word (half-rate mode).

The block is clocked at twice the sample rate. An internal phase bit marks the two halves of a sample period, so half-period latencies and outputs that move on the falling sample-clock edge are ordinary register delays. Edges after reset release are numbered 0, 1, 2, and so on. Even edges are sample-clock rising edges: sample k is captured on edge 2k. Odd edges are falling edges, and every output changes only on one of them. The ratio, release and data-ready mode inputs are taken into the block while reset is held.

Top module: `sdmx_top`

## Requirements
- R1: While `rst_n` is low, after one clock edge, `port_a` to `port_d`, `dr` and `out_valid` are all zero.
- R2: With `ratio_sel`=0 (1:4) and `stag_sel`=0 (simultaneous), samples 4g, 4g+1, 4g+2 and 4g+3 load into ports A, B, C and D together on edge 8g+15. The latencies are therefore 15, 13, 11 and 9 half-cycles.
- R3: With `ratio_sel`=1 (1:2) and `stag_sel`=0, samples 2g and 2g+1 load into ports A and B on edge 4g+11, which gives latencies of 11 and 9 half-cycles. In 1:2 ratio, ports C and D stay zero in every release mode.
- R4: With `stag_sel`=1 (staggered), sample k loads on edge 2k+9, a latency of 9 half-cycles. It goes into port k mod 4 in 1:4 ratio and into port k mod 2 in 1:2 ratio.
- R5: Port outputs and `dr` change only on odd edges (falling sample-clock edges).
- R6: With `drm_sel`=1 (full-rate), `dr` falls on every port A load edge. It rises N half-cycles after that edge, where N is 4 in 1:4 ratio and 2 in 1:2 ratio.
- R7: With `drm_sel`=0 (half-rate), `dr` toggles N half-cycles after each port A load and changes at no other time. N is as in R6.
- R8: `dr` stays low until the first port A load. `out_valid` rises on the first load of the last active port (D in 1:4 ratio, B in 1:2 ratio) and then stays high until reset.
- R9: Changes on `ratio_sel`, `stag_sel` or `drm_sel` while `rst_n` is high have no effect. Only their values during reset are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the sample rate |
| rst_n | input | 1 | Synchronous active-low reset; configuration is taken while it is low |
| ratio_sel | input | 1 | 0 = 1:4 over ports A–D, 1 = 1:2 over ports A–B |
| stag_sel | input | 1 | 0 = simultaneous release, 1 = staggered release |
| drm_sel | input | 1 | 0 = half-rate data-ready (toggle per word), 1 = full-rate data-ready |
| din | input | 10 | Sample input, captured on even edges |
| port_a | output | 10 | Output word A |
| port_b | output | 10 | Output word B |
| port_c | output | 10 | Output word C |
| port_d | output | 10 | Output word D |
| dr | output | 1 | Data-ready clock centred on the output words |
| out_valid | output | 1 | Set once the pipeline has filled every active port |

## Verification
A wrong phase bit or sample counter shows up at the ports within one word period. The port contents shift by one sample, or the loads land on even edges, and the very next compare catches either error. If the history tap selection is off, a port carries a sample from the wrong position in the sequence. An incrementing input stream turns that into an off-by-n value on the first load. A data-ready counter that drifts moves an edge of `dr` by one or more half-cycles within the first word after port A starts loading. A wrongly latched configuration changes which ports load on the first group.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
    localparam int NPORT    = 4;   // output words A..D
    localparam int HIST_D   = 8;   // sample history depth (covers longest latency)
    localparam int STAG_TAP = 4;   // history tap giving 9 half-cycle latency

    typedef enum logic {
        RATIO_QUAD = 1'b0,
        RATIO_PAIR = 1'b1
    } ratio_e;

    typedef struct packed {
        ratio_e ratio;
        logic   stag;
        logic   drfull;
    } dmx_cfg_t;
endpackage

// File: rtl/dmx_hist.sv
module dmx_hist #(
    parameter int W     = 10,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       shift,
    input  logic [W-1:0]               din,
    output logic [DEPTH-1:0][W-1:0]    taps
);
    logic [DEPTH-1:0][W-1:0] taps_d, taps_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign taps_d[i] = shift ? din : taps_q[i];
        end else begin : g_body
            assign taps_d[i] = shift ? taps_q[i-1] : taps_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) taps_q <= '0;
        else        taps_q <= taps_d;
    end

    assign taps = taps_q;
endmodule

// File: rtl/dmx_dready.sv
module dmx_dready (
    input  logic clk,
    input  logic rst_n,
    input  logic pair,     // 1:2 ratio selected
    input  logic drfull,   // full-rate data-ready selected
    input  logic upd_a,    // port A loads on this edge
    output logic dr
);
    typedef struct packed {
        logic [2:0] ctr;
        logic       run;
        logic       dr;
    } dr_st_t;

    dr_st_t s_d, s_q;
    logic [2:0] mid;
    logic       at_mid;

    always_comb begin
        mid    = pair ? 3'd1 : 3'd3;
        at_mid = s_q.run && (s_q.ctr == mid) && !upd_a;
        s_d     = s_q;
        s_d.ctr = upd_a ? 3'd0 : s_q.ctr + 3'd1;
        s_d.run = s_q.run | upd_a;
        if (drfull) begin
            if (upd_a)       s_d.dr = 1'b0;
            else if (at_mid) s_d.dr = 1'b1;
        end else if (at_mid) begin
            s_d.dr = ~s_q.dr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dr = s_q.dr;
endmodule

// File: rtl/sdmx_top.sv
module sdmx_top
    import dmx_pkg::*;
#(
    parameter int SAMP_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ratio_sel,
    input  logic              stag_sel,
    input  logic              drm_sel,
    input  logic [SAMP_W-1:0] din,
    output logic [SAMP_W-1:0] port_a,
    output logic [SAMP_W-1:0] port_b,
    output logic [SAMP_W-1:0] port_c,
    output logic [SAMP_W-1:0] port_d,
    output logic              dr,
    output logic              out_valid
);
    localparam int FILL_W = $clog2(HIST_D + 1);

    typedef struct packed {
        logic                          phase;  // 1 on odd (falling) edges
        logic [1:0]                    pos;    // captured count mod 4
        logic [FILL_W-1:0]             fill;   // captured count, saturating
        dmx_cfg_t                      cfg;
        logic [NPORT-1:0][SAMP_W-1:0]  port;
        logic                          valid;
    } st_t;

    st_t s_d, s_q;
    dmx_cfg_t cfg_in;
    logic [HIST_D-1:0][SAMP_W-1:0] hist;
    logic [1:0] kmod, sp, last_p;
    logic [FILL_W-1:0] thr_m;
    logic fire_s, fire_m, upd_a, pair;
    int   nact;

    assign cfg_in = '{ratio: ratio_e'(ratio_sel), stag: stag_sel, drfull: drm_sel};
    assign pair   = (s_q.cfg.ratio == RATIO_PAIR);

    dmx_hist #(.W(SAMP_W), .DEPTH(HIST_D)) u_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (!s_q.phase),
        .din   (din),
        .taps  (hist)
    );

    always_comb begin
        s_d       = s_q;
        s_d.phase = ~s_q.phase;
        if (!s_q.phase) begin
            s_d.pos = s_q.pos + 2'd1;
            if (s_q.fill != FILL_W'(HIST_D)) s_d.fill = s_q.fill + 1'b1;
        end

        nact   = pair ? 2 : NPORT;
        kmod   = s_q.pos - 2'd1;
        sp     = pair ? {1'b0, kmod[0]} : kmod;
        last_p = pair ? 2'd1 : 2'd3;
        thr_m  = FILL_W'(nact + STAG_TAP);

        fire_s = s_q.phase && s_q.cfg.stag && (s_q.fill >= FILL_W'(STAG_TAP + 1));
        fire_m = s_q.phase && !s_q.cfg.stag && (s_q.fill >= thr_m) && (sp == last_p);

        if (fire_s) begin
            s_d.port[sp] = hist[STAG_TAP];
            if (sp == last_p) s_d.valid = 1'b1;
        end
        if (fire_m) begin
            for (int p = 0; p < NPORT; p++) begin
                if (p < nact) s_d.port[p] = hist[STAG_TAP + nact - 1 - p];
            end
            s_d.valid = 1'b1;
        end

        upd_a = s_q.cfg.stag ? (fire_s && sp == 2'd0) : fire_m;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.cfg <= cfg_in;
        end else begin
            s_q <= s_d;
        end
    end

    dmx_dready u_dready (
        .clk    (clk),
        .rst_n  (rst_n),
        .pair   (pair),
        .drfull (s_q.cfg.drfull),
        .upd_a  (upd_a),
        .dr     (dr)
    );

    logic phase_w;
    assign phase_w   = s_q.phase;
    assign port_a    = s_q.port[0];
    assign port_b    = s_q.port[1];
    assign port_c    = s_q.port[2];
    assign port_d    = s_q.port[3];
    assign out_valid = s_q.valid;
endmodule

// File: rtl/sdmx_chk.sv
module sdmx_chk #(
    parameter int SAMP_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              phase,
    input logic              pair,
    input logic [SAMP_W-1:0] port_a,
    input logic [SAMP_W-1:0] port_b,
    input logic [SAMP_W-1:0] port_c,
    input logic [SAMP_W-1:0] port_d,
    input logic              dr,
    input logic              out_valid
);
    // R3: unused ports stay clear in 1:2 ratio
    p_unused_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pair |-> (port_c == '0 && port_d == '0));

    // R5: nothing loads on a rising sample-clock edge
    p_port_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !phase |=> $stable({port_a, port_b, port_c, port_d}));

    // R6: data-ready edges also fall on falling sample-clock edges only
    p_dr_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !phase |=> $stable(dr));

    // R8: valid is sticky
    p_valid_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> out_valid);
endmodule

bind sdmx_top sdmx_chk #(.SAMP_W(SAMP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase_w),
    .pair      (pair),
    .port_a    (port_a),
    .port_b    (port_b),
    .port_c    (port_c),
    .port_d    (port_d),
    .dr        (dr),
    .out_valid (out_valid)
);

// File: tb/tb_sdmx_top.sv
module tb_sdmx_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ratio_sel = 1'b0, stag_sel = 1'b0, drm_sel = 1'b0;
    logic [9:0] din = '0;
    logic [9:0] port_a, port_b, port_c, port_d;
    logic dr, out_valid;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdmx_top dut (
        .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .stag_sel(stag_sel),
        .drm_sel(drm_sel), .din(din), .port_a(port_a), .port_b(port_b),
        .port_c(port_c), .port_d(port_d), .dr(dr), .out_valid(out_valid)
    );

    int n_vec = 0, n_bad = 0;

    // behavioural model state
    int  ep[4];
    bit  edr, evalid, runa;
    int  last_a, base, nr;
    bit  m_pair, m_stag, m_drf;
    logic [39:0] prev_ports;

    function automatic int samp(int k);
        return (base + k) % 1024;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // model update for edge number e after reset release
    task automatic model_edge(int e);
        bit aupd = 0;
        if (e % 2 == 1) begin
            if (m_stag) begin
                if (e >= 9) begin
                    int k = (e - 9) / 2;
                    int p = k % nr;
                    ep[p] = samp(k);
                    if (p == nr - 1) evalid = 1;
                    if (p == 0) aupd = 1;
                end
            end else begin
                int f = 2 * nr + 7;
                if (e >= f && (e - f) % (2 * nr) == 0) begin
                    int g = (e - f) / (2 * nr);
                    for (int p = 0; p < nr; p++) ep[p] = samp(nr * g + p);
                    evalid = 1;
                    aupd = 1;
                end
            end
        end
        if (aupd) begin
            last_a = e;
            runa = 1;
            if (m_drf) edr = 0;
        end else if (runa && e == last_a + nr) begin
            if (m_drf) edr = 1;
            else       edr = ~edr;
        end
    endtask

    task automatic compare(int e, string ovr);
        string tp, td;
        tp = m_stag ? "R4" : (m_pair ? "R3" : "R2");
        td = m_drf ? "R6" : "R7";
        if (ovr != "") begin tp = ovr; td = ovr; end
        chk({tp, " port_a"}, int'(port_a), ep[0]);
        chk({tp, " port_b"}, int'(port_b), ep[1]);
        chk({tp, " port_c"}, int'(port_c), ep[2]);
        chk({tp, " port_d"}, int'(port_d), ep[3]);
        chk({td, " dr"}, int'(dr), int'(edr));
        chk("R8 out_valid", int'(out_valid), int'(evalid));
        if (e % 2 == 0) // R5: even edge, ports must hold
            chk("R5 ports held on even edge", int'({port_a, port_b, port_c, port_d} != prev_ports), 0);
        prev_ports = {port_a, port_b, port_c, port_d};
    endtask

    task automatic run_cfg(bit pr, bit st, bit drf, int nedge, bit flip, int b);
        @(negedge clk);
        rst_n = 0; ratio_sel = pr; stag_sel = st; drm_sel = drf; din = 10'h3ff;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset clears every output
        chk("R1 port_a", int'(port_a), 0);
        chk("R1 port_b", int'(port_b), 0);
        chk("R1 port_c", int'(port_c), 0);
        chk("R1 port_d", int'(port_d), 0);
        chk("R1 dr", int'(dr), 0);
        chk("R1 out_valid", int'(out_valid), 0);
        m_pair = pr; m_stag = st; m_drf = drf; nr = pr ? 2 : 4; base = b;
        for (int i = 0; i < 4; i++) ep[i] = 0;
        edr = 0; evalid = 0; runa = 0; last_a = 0; prev_ports = '0;
        rst_n = 1;
        for (int e = 0; e < nedge; e++) begin
            if (e % 2 == 0) din = 10'(samp(e / 2));
            if (flip && e == 30) begin
                // R9: configuration changes outside reset are ignored
                ratio_sel = ~pr; stag_sel = ~st; drm_sel = ~drf;
            end
            @(posedge clk);
            model_edge(e);
            @(negedge clk);
            compare(e, (flip && e > 30) ? "R9" : "");
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 8; c++)
            run_cfg(c[0], c[1], c[2], 120, 1'b0, 1000 + 7 * c);
        run_cfg(1'b0, 1'b0, 1'b1, 100, 1'b1, 5);
        run_cfg(1'b1, 1'b1, 1'b0, 100, 1'b1, 900);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule